// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block produces the memory address stream for a single DMA work unit. A start address, an inner (X) count with its signed stride, and an outer (Y) count with its own signed stride are captured by a one-cycle load strobe. The block then offers one address at a time on a valid/ready handshake. Each accepted beat advances the walk: along a row by the X stride, and from the last element of a row to the first of the next by the Y stride.

In 1-D operation only the X parameters count, and the work unit is a single row. At the end of a work unit the block pulses a done flag, and also an interrupt request if that was enabled at load time. In stop flow it then goes idle. In autobuffer flow it reloads the start address and both counts and carries on until the channel is disabled. A count of zero is refused: an error flag is raised and the walk does not start. The live X and Y counts are visible on output ports throughout.

Top module: `dma2d_addr_gen`

## Requirements
- R1: One cycle after a load strobe with valid counts, `busy` and `addr_valid` are 1, `addr_out` equals the start address, `cur_x` equals the X count, and `cur_y` equals the Y count (2-D) or 1 (1-D).
- R2: A beat accepted while `cur_x` is greater than 1 makes the next address the current address plus the sign-extended X stride, and lowers `cur_x` by one.
- R3: A beat accepted while `cur_x` is 1 and `cur_y` is greater than 1 makes the next address the current address plus the sign-extended Y stride, reloads `cur_x` with the X count, and lowers `cur_y` by one.
- R4: With `cfg_two_d` = 0 the Y count and Y stride have no effect: the unit is X beats long, `cur_y` reads 1, and a Y count of 0 is not an error.
- R5: `unit_done` is 1 for exactly the cycle after the final beat of a work unit (`cur_x` = 1 and `cur_y` = 1), and 0 otherwise.
- R6: `irq` equals `unit_done` when `cfg_irq_en` was 1 at load, and stays 0 when it was 0.
- R7: In stop flow (`cfg_autobuf` = 0), `busy` and `addr_valid` are 0 from the cycle after the final beat, and `addr_ready` has no effect on the outputs until the next load.
- R8: In autobuffer flow (`cfg_autobuf` = 1), the final beat restores the start address and both counts and the walk continues. `chan_disable` clears `busy` on the next cycle. A load in the same cycle takes priority over `chan_disable`.
- R9: A load with X count 0, or with Y count 0 in 2-D mode, sets `cfg_err` and leaves `busy` at 0. The next valid load clears `cfg_err`.
- R10: While `addr_valid` is 1 and `addr_ready` is 0, `addr_out`, `cur_x` and `cur_y` hold their values.
- R11: After reset, `busy`, `addr_valid`, `unit_done`, `irq` and `cfg_err` are 0, and `cur_x` and `cur_y` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | One-cycle strobe that captures the parameters and starts a walk |
| cfg_start | input | AW | First address of the work unit |
| cfg_x_count | input | CW | Beats per row |
| cfg_x_mod | input | MW | Signed stride within a row |
| cfg_y_count | input | CW | Number of rows (2-D only) |
| cfg_y_mod | input | MW | Signed stride from a row's last address to the next row's first |
| cfg_two_d | input | 1 | 1 selects a 2-D walk, 0 a single row |
| cfg_autobuf | input | 1 | 1 repeats the unit, 0 stops after it |
| cfg_irq_en | input | 1 | Enables the interrupt pulse at unit end |
| chan_disable | input | 1 | Stops the walk |
| addr_valid | output | 1 | An address is offered |
| addr_ready | input | 1 | The consumer accepts the offered address |
| addr_out | output | AW | Offered address |
| busy | output | 1 | A walk is in progress |
| unit_done | output | 1 | One-cycle pulse after the final beat of a unit |
| irq | output | 1 | Interrupt pulse, gated by the enable captured at load |
| cfg_err | output | 1 | The last load held an illegal zero count |
| cur_x | output | CW | Live inner count |
| cur_y | output | CW | Live outer count |

## Verification
The assertions assume that `cfg_load` and `chan_disable` are single, well-formed strobes. They also assume that the parameter inputs matter only in the cycle of the load, since the stride checks compare against the captured copies and not against the live pins. The bench changes parameters only together with a load strobe, on the inactive clock edge. It sweeps every combination of small X and Y counts with positive and negative strides in both modes. It varies `addr_ready` in several duty patterns, so that stalls land at row ends and at unit ends.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  // What the address register does on a given cycle
  typedef enum logic [1:0] {
    STEP_HOLD   = 2'd0,
    STEP_X      = 2'd1,
    STEP_Y      = 2'd2,
    STEP_RELOAD = 2'd3
  } step_e;
endpackage

// File: rtl/dma2d_count_reg.sv
module dma2d_count_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set,
  input  logic [W-1:0] set_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         at_last
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (set) cnt <= set_val;
    else if (dec) cnt <= cnt - ONE;
  end

  assign at_last = (cnt == ONE);

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !dec) |=> $stable(cnt)); // R10

  AST_CNT_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !set) |-> (cnt != '0)); // R2
endmodule

// File: rtl/dma2d_addr_walk.sv
module dma2d_addr_walk
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int MW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [AW-1:0]        start,
  input  step_e                step,
  input  logic signed [MW-1:0] x_mod,
  input  logic signed [MW-1:0] y_mod,
  output logic [AW-1:0]        addr
);
  logic [AW-1:0] start_q;

  // Address plus sign-extended stride, wrapping modulo 2^AW
  function automatic logic [AW-1:0] add_stride(input logic [AW-1:0] a,
                                               input logic signed [MW-1:0] m);
    return a + AW'(m);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0;
      addr    <= '0;
    end else if (load) begin
      start_q <= start;
      addr    <= start;
    end else begin
      unique case (step)
        STEP_X:      addr <= add_stride(addr, x_mod);
        STEP_Y:      addr <= add_stride(addr, y_mod);
        STEP_RELOAD: addr <= start_q;
        default:     addr <= addr;
      endcase
    end
  end

  AST_RELOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step == STEP_RELOAD) |=> (addr == start_q)); // R8

  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (addr == $past(start))); // R1
endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen
  import dma2d_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int MW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_load,
  input  logic [AW-1:0]        cfg_start,
  input  logic [CW-1:0]        cfg_x_count,
  input  logic signed [MW-1:0] cfg_x_mod,
  input  logic [CW-1:0]        cfg_y_count,
  input  logic signed [MW-1:0] cfg_y_mod,
  input  logic                 cfg_two_d,
  input  logic                 cfg_autobuf,
  input  logic                 cfg_irq_en,
  input  logic                 chan_disable,
  output logic                 addr_valid,
  input  logic                 addr_ready,
  output logic [AW-1:0]        addr_out,
  output logic                 busy,
  output logic                 unit_done,
  output logic                 irq,
  output logic                 cfg_err,
  output logic [CW-1:0]        cur_x,
  output logic [CW-1:0]        cur_y
);
  localparam logic [CW-1:0] ONE = CW'(1);

  // Captured configuration
  logic                 active_q, err_q, done_q, irq_q;
  logic                 autobuf_q, irq_en_q;
  logic [CW-1:0]        x_reload_q, y_reload_q;
  logic signed [MW-1:0] x_mod_q, y_mod_q;

  // Named internal events
  logic    cfg_bad, load_ok, beat, x_last, y_last, row_end, unit_end;
  logic    x_set, y_set, x_dec, y_dec;
  logic [CW-1:0] x_set_val, y_set_val, y_load_val;
  step_e   step;

  assign cfg_bad    = (cfg_x_count == '0) || (cfg_two_d && cfg_y_count == '0);
  assign load_ok    = cfg_load && !cfg_bad;
  assign beat       = active_q && addr_ready;
  assign row_end    = beat && x_last && !y_last;
  assign unit_end   = beat && x_last && y_last;
  assign y_load_val = cfg_two_d ? cfg_y_count : ONE;

  always_comb begin
    if (!beat)        step = STEP_HOLD;
    else if (!x_last) step = STEP_X;
    else if (!y_last) step = STEP_Y;
    else if (autobuf_q) step = STEP_RELOAD;
    else              step = STEP_HOLD;
  end

  assign x_set     = load_ok || row_end || (unit_end && autobuf_q);
  assign x_set_val = load_ok ? cfg_x_count : x_reload_q;
  assign x_dec     = beat && !x_last;
  assign y_set     = load_ok || (unit_end && autobuf_q);
  assign y_set_val = load_ok ? y_load_val : y_reload_q;
  assign y_dec     = row_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
      irq_q      <= 1'b0;
      autobuf_q  <= 1'b0;
      irq_en_q   <= 1'b0;
      x_reload_q <= '0;
      y_reload_q <= '0;
      x_mod_q    <= '0;
      y_mod_q    <= '0;
    end else begin
      done_q <= unit_end;
      irq_q  <= unit_end && irq_en_q;
      if (cfg_load) begin
        err_q    <= cfg_bad;
        active_q <= !cfg_bad;
        if (!cfg_bad) begin
          autobuf_q  <= cfg_autobuf;
          irq_en_q   <= cfg_irq_en;
          x_reload_q <= cfg_x_count;
          y_reload_q <= y_load_val;
          x_mod_q    <= cfg_x_mod;
          y_mod_q    <= cfg_two_d ? cfg_y_mod : '0;
        end
      end else if (chan_disable) begin
        active_q <= 1'b0;
      end else if (unit_end && !autobuf_q) begin
        active_q <= 1'b0;
      end
    end
  end

  dma2d_count_reg #(.W(CW)) x_ctr_i (
    .clk(clk), .rst_n(rst_n), .set(x_set), .set_val(x_set_val),
    .dec(x_dec), .cnt(cur_x), .at_last(x_last)
  );

  dma2d_count_reg #(.W(CW)) y_ctr_i (
    .clk(clk), .rst_n(rst_n), .set(y_set), .set_val(y_set_val),
    .dec(y_dec), .cnt(cur_y), .at_last(y_last)
  );

  dma2d_addr_walk #(.AW(AW), .MW(MW)) walk_i (
    .clk(clk), .rst_n(rst_n), .load(load_ok), .start(cfg_start),
    .step(step), .x_mod(x_mod_q), .y_mod(y_mod_q), .addr(addr_out)
  );

  assign addr_valid = active_q;
  assign busy       = active_q;
  assign unit_done  = done_q;
  assign irq        = irq_q;
  assign cfg_err    = err_q;

  AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !x_last && !cfg_load) |=>
      (addr_out == $past(addr_out) + AW'($past(x_mod_q)))); // R2

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (row_end && !cfg_load) |=>
      (addr_out == $past(addr_out) + AW'($past(y_mod_q)) && cur_x == x_reload_q)); // R3

  AST_DONE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    unit_end |=> unit_done); // R5

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> unit_done); // R6

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_end && !autobuf_q && !cfg_load) |=> !busy); // R7

  AST_AUTO_CONTINUE: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_end && autobuf_q && !cfg_load && !chan_disable) |=>
      (busy && cur_x == x_reload_q && cur_y == y_reload_q)); // R8

  AST_ERR_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && cfg_bad) |=> (cfg_err && !busy)); // R9

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready && !cfg_load && !chan_disable) |=>
      ($stable(addr_out) && $stable(cur_x) && $stable(cur_y))); // R10

  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cur_x != '0 && cur_y != '0)); // R1
endmodule

// File: tb/dma2d_addr_gen_tb_top.sv
`timescale 1ns/1ps
module dma2d_addr_gen_tb_top;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int MW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic [AW-1:0] cfg_start = '0;
  logic [CW-1:0] cfg_x_count = '0;
  logic signed [MW-1:0] cfg_x_mod = '0;
  logic [CW-1:0] cfg_y_count = '0;
  logic signed [MW-1:0] cfg_y_mod = '0;
  logic cfg_two_d = 1'b0, cfg_autobuf = 1'b0, cfg_irq_en = 1'b0;
  logic chan_disable = 1'b0, addr_ready = 1'b0;
  logic addr_valid, busy, unit_done, irq, cfg_err;
  logic [AW-1:0] addr_out;
  logic [CW-1:0] cur_x, cur_y;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  dma2d_addr_gen #(.AW(AW), .CW(CW), .MW(MW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_start(cfg_start),
    .cfg_x_count(cfg_x_count), .cfg_x_mod(cfg_x_mod), .cfg_y_count(cfg_y_count),
    .cfg_y_mod(cfg_y_mod), .cfg_two_d(cfg_two_d), .cfg_autobuf(cfg_autobuf),
    .cfg_irq_en(cfg_irq_en), .chan_disable(chan_disable), .addr_valid(addr_valid),
    .addr_ready(addr_ready), .addr_out(addr_out), .busy(busy), .unit_done(unit_done),
    .irq(irq), .cfg_err(cfg_err), .cur_x(cur_x), .cur_y(cur_y)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_load(input logic [AW-1:0] st, input int x, input int y,
                         input int xm, input int ym, input bit td,
                         input bit ab, input bit ie);
    @(negedge clk);
    cfg_start = st; cfg_x_count = CW'(x); cfg_y_count = CW'(y);
    cfg_x_mod = MW'(xm); cfg_y_mod = MW'(ym);
    cfg_two_d = td; cfg_autobuf = ab; cfg_irq_en = ie;
    cfg_load = 1'b1; addr_ready = 1'b0;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  // Runs one configuration; the expected walk is computed from row/column indices
  task automatic run_unit(input logic [AW-1:0] st, input int x, input int y,
                          input int xm, input int ym, input bit td, input bit ab,
                          input bit ie, input int passes, input int pat);
    int yy, per, total, idx, cyc;
    bit prev_end, prev_stall;
    logic [AW-1:0] prev_addr;
    logic [CW-1:0] prev_x;
    yy = td ? y : 1;
    per = x * yy;
    total = per * passes;
    do_load(st, x, y, xm, ym, td, ab, ie);
    chk(busy === 1'b1 && cfg_err === 1'b0, "R1", "busy after load", busy, 1);
    chk(addr_out === st, "R1", "first address", addr_out, st);
    chk(cur_x === CW'(x), "R1", "cur_x after load", cur_x, x);
    chk(cur_y === CW'(yy), td ? "R1" : "R4", "cur_y after load", cur_y, yy);
    idx = 0; cyc = 0; prev_end = 0; prev_stall = 0;
    prev_addr = '0; prev_x = '0;
    while (idx < total) begin
      addr_ready = (pat == 0) ? 1'b1 : ((cyc % (pat + 1)) != 0);
      chk(unit_done === prev_end, "R5", "done pulse", unit_done, prev_end);
      chk(irq === (prev_end && ie), "R6", "irq pulse", irq, prev_end && ie);
      if (prev_stall) begin
        chk(addr_out === prev_addr && cur_x === prev_x, "R10", "hold while stalled",
            addr_out, prev_addr);
      end
      prev_end = 0; prev_stall = 0;
      if (addr_valid && addr_ready) begin
        int k, r, c;
        longint e;
        k = idx % per; r = k / x; c = k % x;
        e = longint'(st) + longint'(r) * (longint'(x - 1) * xm + ym) + longint'(c) * xm;
        chk(addr_out === AW'(e), (c != 0) ? "R2" : ((r != 0) ? "R3" : "R8"),
            "beat address", addr_out, AW'(e));
        chk(cur_x === CW'(x - c), "R2", "cur_x at beat", cur_x, x - c);
        chk(cur_y === CW'(yy - r), td ? "R3" : "R4", "cur_y at beat", cur_y, yy - r);
        idx++;
        prev_end = (idx % per) == 0;
      end else begin
        chk(addr_valid === 1'b1, "R8", "valid during walk", addr_valid, 1);
        prev_stall = 1;
        prev_addr = addr_out; prev_x = cur_x;
      end
      cyc++;
      @(negedge clk);
    end
    addr_ready = 1'b0;
    chk(unit_done === 1'b1, "R5", "done after final beat", unit_done, 1);
    chk(irq === ie, "R6", "irq after final beat", irq, ie);
    if (!ab) begin
      chk(busy === 1'b0 && addr_valid === 1'b0, "R7", "idle after stop", busy, 0);
      addr_ready = 1'b1;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(addr_valid === 1'b0 && unit_done === 1'b0, "R7", "ready ignored when idle",
            addr_valid, 0);
        chk(cur_x === CW'(1) && cur_y === CW'(1), "R7", "counts frozen", cur_x, 1);
      end
      addr_ready = 1'b0;
    end else begin
      chk(busy === 1'b1 && addr_out === st, "R8", "autobuffer reload address", addr_out, st);
      chk(cur_x === CW'(x) && cur_y === CW'(yy), "R8", "autobuffer reload counts", cur_x, x);
      chan_disable = 1'b1;
      @(negedge clk);
      chan_disable = 1'b0;
      chk(busy === 1'b0, "R8", "disable stops autobuffer", busy, 0);
      chk(unit_done === 1'b0, "R5", "done single cycle", unit_done, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy === 1'b0 && addr_valid === 1'b0, "R11", "reset busy/valid", busy, 0);
    chk(unit_done === 1'b0 && irq === 1'b0 && cfg_err === 1'b0, "R11", "reset flags", unit_done, 0);
    chk(cur_x === '0 && cur_y === '0, "R11", "reset counts", cur_x, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && cur_x === '0, "R11", "idle after reset", busy, 0);

    // Sweep: both modes, small counts, positive and negative strides
    for (int td = 0; td < 2; td++)
      for (int x = 1; x <= 4; x++)
        for (int y = 1; y <= 3; y++)
          for (int m = 0; m < 2; m++) begin
            int xm, ym;
            xm = (m == 0) ? 4 : -2;
            ym = (m == 0) ? 16 : -40;
            run_unit(32'h0000_1000, x, y, xm, ym, td[0], 1'b0, x[0], 1, (x + y + m) % 3);
          end

    // R4: 1-D with a zero Y count and a wild Y stride is legal
    run_unit(32'h0000_2000, 3, 0, 8, 1234, 1'b0, 1'b0, 1'b1, 1, 0);

    // R8: autobuffer in 2-D and 1-D, with a stride that wraps below zero
    run_unit(32'h0000_0004, 3, 2, -4, 100, 1'b1, 1'b1, 1'b1, 3, 2);
    run_unit(32'h0000_0300, 2, 5, 1, 0, 1'b0, 1'b1, 1'b0, 2, 1);

    // R9: illegal zero counts
    do_load(32'h0000_5000, 0, 2, 1, 1, 1'b1, 1'b0, 1'b0);
    chk(cfg_err === 1'b1 && busy === 1'b0, "R9", "zero X count refused", cfg_err, 1);
    addr_ready = 1'b1;
    @(negedge clk);
    chk(addr_valid === 1'b0, "R9", "no walk after error", addr_valid, 0);
    addr_ready = 1'b0;
    do_load(32'h0000_5000, 2, 0, 1, 1, 1'b1, 1'b0, 1'b0);
    chk(cfg_err === 1'b1 && busy === 1'b0, "R9", "zero Y count in 2-D refused", cfg_err, 1);
    run_unit(32'h0000_6000, 2, 2, 2, 10, 1'b1, 1'b0, 1'b0, 1, 0);
    chk(cfg_err === 1'b0, "R9", "error cleared by valid load", cfg_err, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule